// File: doc/BRIEF.md
# Card Transaction Authorization Sequencer

This controller sequences one withdrawal session at a card terminal that can reach several bank accounts through a single card. A card-present pulse opens the session, and a fingerprint verdict follows. When the fingerprint matches, the holder goes straight to choosing an account. When it does not match, the controller sends a strobe to the phone-message modem to ask the holder for a one-time code. It then waits a programmable number of cycles for the reply. A reply leads to account choice and then keypad entry of that code. A timeout blocks the session.

All decisions are made in one registered state machine. A digit shift register holds the keypad entry and compares it with the code received in the reply. A reply timer and a buzzer timer each have their own small counter. Every outcome (grant, cancel, block) is a one-cycle pulse, and after each one the controller goes back to waiting for a new card.

Top module: `card_auth_seq`

## Requirements
- R1: Under reset, every strobe output is low, the buzzer is off and the selected bank index is 0.
- R2: Only a card-present pulse starts a session, and only while idle. Fingerprint, reply and key events that arrive while idle have no effect.
- R3: A fingerprint verdict of "no match" produces a one-cycle code-request strobe in the cycle after the verdict. A "match" verdict produces no strobe and moves to bank choice.
- R4: After the code-request strobe, if no reply arrives, a one-cycle block strobe comes exactly max(1, timeout) cycles later and the controller returns to idle. A reply that arrives in the expiry cycle wins over the timeout.
- R5: During bank choice, a key whose 4-bit code is below the configured bank count (3) sets the bank index to that code. Any other key is ignored, and the bank index keeps its value.
- R6: Keypad digit codes 0–9 shift into a 4-digit entry. The first typed digit lands in the most significant nibble, and only the last four digits are kept. Key code 0xE (enter) compares the entry with the reply code, where each digit is a BCD nibble and the first digit is in bits 15:12. Codes 0xA–0xD and 0xF are ignored.
- R7: A matching entry produces grant and confirmation-request strobes in the same cycle, then the controller returns to idle.
- R8: A mismatching entry clears the typed digits. On the third consecutive mismatch the controller produces a one-cycle cancel strobe, turns the buzzer on for exactly 8 cycles starting in that same cycle, and returns to idle.
- R9: The wrong-entry count is cleared by a match and by a new card, so mismatches from earlier sessions or before a match do not count toward a cancel.
- R10: On the fingerprint-match path, picking a valid bank produces grant and confirmation-request strobes at once, with no code entry.
- R11: At most one of grant, cancel and block is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_i | input | 1 | Card-present pulse |
| bio_done_i | input | 1 | Fingerprint verdict valid |
| bio_ok_i | input | 1 | Fingerprint verdict: 1 = match |
| reply_valid_i | input | 1 | Holder's code reply received |
| reply_code_i | input | 16 | Replied code, 4 BCD digits, first digit in the top nibble |
| timeout_i | input | 16 | Reply wait limit in cycles (0 acts as 1) |
| key_valid_i | input | 1 | Keypad key pulse |
| key_code_i | input | 4 | Key code: 0–9 digits, 0xE enter |
| otp_req_o | output | 1 | Strobe: ask holder for a code by phone message |
| confirm_req_o | output | 1 | Strobe: send confirmation message |
| bank_sel_o | output | 2 | Selected bank index |
| grant_o | output | 1 | Transaction granted strobe |
| cancel_o | output | 1 | Transaction cancelled strobe |
| blocked_o | output | 1 | Transaction blocked (no reply) strobe |
| buzzer_o | output | 1 | Buzzer enable |

## Verification
The holder's reply and the expiry of the reply timer can fall in the same cycle. The bench sweeps the timeout from 1 to 5 and checks that the block strobe lands exactly on the computed cycle. It then sends the reply in exactly the expiry cycle and requires that no block strobe appears and that the session goes on to bank choice and a grant. A second collision is the third mismatch, which must raise cancel and buzzer together in one cycle. The bench then counts buzzer cycles and checks that an idle-state event no longer starts anything.

// File: rtl/auth_pkg.sv
package auth_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIO,
        ST_REPLY,
        ST_BANK,
        ST_PIN
    } seq_state_e;

    localparam logic [3:0] KEY_ENTER = 4'hE;
    localparam logic [3:0] KEY_MAXDIG = 4'd9;
endpackage

// File: rtl/pin_shift.sv
module pin_shift #(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic [3:0]   digit_i,
    input  logic [W-1:0] ref_i,
    output logic         match_o
);
    typedef struct packed {
        logic [W-1:0] digits;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.digits = '0;
        end else if (shift_i) begin
            s_d.digits = (s_q.digits << 4) | W'(digit_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign match_o = (s_q.digits == ref_i);

    // R6: a clear empties the entry on the following cycle
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.digits == '0));
endmodule

// File: rtl/reply_timer.sv
module reply_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W:0] lim_eff;

    assign lim_eff = (limit_i == '0) ? (CNT_W+1)'(1) : {1'b0, limit_i};

    always_comb begin
        t_d = t_q;
        if (start_i)    t_d.cnt = '0;
        else if (run_i) t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expire_o = run_i && (({1'b0, t_q.cnt} + 1'b1) >= lim_eff);

    // R4: the controller leaves the wait before the count passes the limit
    a_r4_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> ({1'b0, t_q.cnt} < lim_eff));
endmodule

// File: rtl/buzz_timer.sv
module buzz_timer #(
    parameter int CYCLES = 8,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic buzz_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } bz_t;

    bz_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (start_i)            b_d.cnt = CW'(CYCLES);
        else if (b_q.cnt != '0) b_d.cnt = b_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign buzz_o = (b_q.cnt != '0);

    // R8: a start turns the buzzer on in the next cycle
    a_r8_buzz_starts: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> buzz_o);
endmodule

// File: rtl/card_auth_seq.sv
module card_auth_seq
    import auth_pkg::*;
#(
    parameter int DIGITS      = 4,
    parameter int BANK_W      = 2,
    parameter int NUM_BANKS   = 3,
    parameter int MAX_TRIES   = 3,
    parameter int TMR_W       = 16,
    parameter int BUZZ_CYCLES = 8,
    localparam int CODE_W     = DIGITS * 4,
    localparam int TRY_W      = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_i,
    input  logic              bio_done_i,
    input  logic              bio_ok_i,
    input  logic              reply_valid_i,
    input  logic [CODE_W-1:0] reply_code_i,
    input  logic [TMR_W-1:0]  timeout_i,
    input  logic              key_valid_i,
    input  logic [3:0]        key_code_i,
    output logic              otp_req_o,
    output logic              confirm_req_o,
    output logic [BANK_W-1:0] bank_sel_o,
    output logic              grant_o,
    output logic              cancel_o,
    output logic              blocked_o,
    output logic              buzzer_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [CODE_W-1:0] code;
        logic [BANK_W-1:0] bank;
        logic [TRY_W-1:0]  tries;
        logic              bio_pass;
        logic              otp;
        logic              confirm;
        logic              grant;
        logic              cancel;
        logic              block;
    } ctl_t;

    ctl_t c_d, c_q;

    logic tmr_start, tmr_expire;
    logic pin_clr, pin_shift_en, pin_match;
    logic buzz_start;
    logic bank_key_ok;

    assign bank_key_ok = key_valid_i && (32'(key_code_i) < NUM_BANKS);

    always_comb begin
        c_d          = c_q;
        c_d.otp      = 1'b0;
        c_d.confirm  = 1'b0;
        c_d.grant    = 1'b0;
        c_d.cancel   = 1'b0;
        c_d.block    = 1'b0;
        tmr_start    = 1'b0;
        pin_clr      = 1'b0;
        pin_shift_en = 1'b0;
        buzz_start   = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (card_i) begin
                    c_d.st       = ST_BIO;
                    c_d.tries    = '0;
                    c_d.bio_pass = 1'b0;
                end
            end
            ST_BIO: begin
                if (bio_done_i) begin
                    if (bio_ok_i) begin
                        c_d.bio_pass = 1'b1;
                        c_d.st       = ST_BANK;
                    end else begin
                        c_d.otp   = 1'b1;
                        tmr_start = 1'b1;
                        c_d.st    = ST_REPLY;
                    end
                end
            end
            ST_REPLY: begin
                if (reply_valid_i) begin
                    c_d.code = reply_code_i;
                    c_d.st   = ST_BANK;
                end else if (tmr_expire) begin
                    c_d.block = 1'b1;
                    c_d.st    = ST_IDLE;
                end
            end
            ST_BANK: begin
                if (bank_key_ok) begin
                    c_d.bank = BANK_W'(key_code_i);
                    if (c_q.bio_pass) begin
                        c_d.grant   = 1'b1;
                        c_d.confirm = 1'b1;
                        c_d.st      = ST_IDLE;
                    end else begin
                        pin_clr = 1'b1;
                        c_d.st  = ST_PIN;
                    end
                end
            end
            ST_PIN: begin
                if (key_valid_i) begin
                    if (key_code_i <= KEY_MAXDIG) begin
                        pin_shift_en = 1'b1;
                    end else if (key_code_i == KEY_ENTER) begin
                        if (pin_match) begin
                            c_d.grant   = 1'b1;
                            c_d.confirm = 1'b1;
                            c_d.tries   = '0;
                            c_d.st      = ST_IDLE;
                        end else if (c_q.tries == TRY_W'(MAX_TRIES - 1)) begin
                            c_d.cancel = 1'b1;
                            buzz_start = 1'b1;
                            c_d.tries  = '0;
                            c_d.st     = ST_IDLE;
                        end else begin
                            c_d.tries = c_q.tries + 1'b1;
                            pin_clr   = 1'b1;
                        end
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    reply_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .run_i    (c_q.st == ST_REPLY),
        .limit_i  (timeout_i),
        .expire_o (tmr_expire)
    );

    pin_shift #(.DIGITS(DIGITS)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pin_clr),
        .shift_i (pin_shift_en),
        .digit_i (key_code_i),
        .ref_i   (c_q.code),
        .match_o (pin_match)
    );

    buzz_timer #(.CYCLES(BUZZ_CYCLES)) u_buzz (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (buzz_start),
        .buzz_o  (buzzer_o)
    );

    assign otp_req_o     = c_q.otp;
    assign confirm_req_o = c_q.confirm;
    assign bank_sel_o    = c_q.bank;
    assign grant_o       = c_q.grant;
    assign cancel_o      = c_q.cancel;
    assign blocked_o     = c_q.block;

    // R11: outcomes are exclusive
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c_q.grant, c_q.cancel, c_q.block}));
    // R3: a code request only follows a fingerprint wait
    a_r3_otp_after_bio: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.otp |-> $past(c_q.st == ST_BIO));
    // R4: a block only ends a reply wait that saw no reply
    a_r4_block_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.block |-> ($past(c_q.st == ST_REPLY) && !$past(reply_valid_i)));
    // R8: cancel and buzzer rise together
    a_r8_cancel_buzzes: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cancel |-> buzzer_o);
    // R8: wrong count stays below the limit
    a_r8_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(c_q.tries) < MAX_TRIES);
    // R5: bank index stays in range
    a_r5_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(c_q.bank) < NUM_BANKS);
    // R9: a grant leaves no wrong count behind
    a_r9_clear_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.grant |-> (c_q.tries == '0));
endmodule

// File: tb/sim_card_auth_seq.sv
`timescale 1ns/1ps
module sim_card_auth_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        card, bio_done, bio_ok, reply_valid, key_valid;
    logic [15:0] reply_code, timeout;
    logic [3:0]  key_code;
    logic        otp, confirm, grant, cancel, blocked, buzzer;
    logic [1:0]  bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    card_auth_seq u0 (
        .clk(clk), .rst_n(rst_n), .card_i(card), .bio_done_i(bio_done),
        .bio_ok_i(bio_ok), .reply_valid_i(reply_valid), .reply_code_i(reply_code),
        .timeout_i(timeout), .key_valid_i(key_valid), .key_code_i(key_code),
        .otp_req_o(otp), .confirm_req_o(confirm), .bank_sel_o(bank),
        .grant_o(grant), .cancel_o(cancel), .blocked_o(blocked), .buzzer_o(buzzer)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_card();
        card = 1'b1; tick(); card = 1'b0;
    endtask

    task automatic do_bio(input bit ok);
        bio_done = 1'b1; bio_ok = ok; tick(); bio_done = 1'b0; bio_ok = 1'b0;
    endtask

    task automatic do_reply(input logic [15:0] c);
        reply_valid = 1'b1; reply_code = c; tick(); reply_valid = 1'b0;
    endtask

    task automatic press(input logic [3:0] k);
        key_valid = 1'b1; key_code = k; tick(); key_valid = 1'b0;
    endtask

    task automatic type_code(input logic [15:0] c);
        for (int i = 3; i >= 0; i--) press(c[i*4 +: 4]);
    endtask

    task automatic open_code_session(input logic [15:0] c, input logic [3:0] b);
        do_card();
        do_bio(1'b0);
        do_reply(c);
        press(b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (R1..R11 run): actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int prev_bank;
        int n;
        rst_n = 1'b0; card = 0; bio_done = 0; bio_ok = 0; reply_valid = 0;
        key_valid = 0; reply_code = '0; key_code = '0; timeout = 16'd4;
        repeat (3) tick();
        // R1 reset state
        check("R1 otp", otp, 0);
        check("R1 grant", grant, 0);
        check("R1 cancel", cancel, 0);
        check("R1 blocked", blocked, 0);
        check("R1 buzzer", buzzer, 0);
        check("R1 bank", bank, 0);
        rst_n = 1'b1;
        tick();

        // R2: events in idle are ignored
        do_bio(1'b0);
        check("R2 idle bio no otp", otp, 0);
        do_reply(16'h1111);
        press(4'h0);
        check("R2 idle key no grant", grant, 0);
        press(4'hE);
        check("R2 idle enter no grant", grant, 0);

        // R4 timeout sweep
        for (int t = 1; t <= 5; t++) begin
            timeout = 16'(t);
            do_card();
            check("R3 card alone no otp", otp, 0);
            do_bio(1'b0);
            check("R3 otp on fail", otp, 1);
            for (int i = 1; i <= t; i++) begin
                tick();
                if (i == 1) check("R3 otp one cycle", otp, 0);
                check($sformatf("R4 block T=%0d i=%0d", t, i), blocked, (i == t) ? 1 : 0);
            end
            tick();
            check("R4 block one cycle", blocked, 0);
            do_bio(1'b0);
            check("R4 idle after block", otp, 0);
        end
        // R4 timeout 0 acts as 1
        timeout = 16'd0;
        do_card(); do_bio(1'b0); tick();
        check("R4 block T=0", blocked, 1);

        // R4 collision: reply in expiry cycle wins
        timeout = 16'd3;
        do_card(); do_bio(1'b0);
        tick(); tick();
        do_reply(16'h1234);
        check("R4 reply beats expiry", blocked, 0);
        tick();
        check("R4 no late block", blocked, 0);
        prev_bank = bank;
        press(4'd3);
        check("R5 key 3 ignored", bank, prev_bank);
        press(4'hE);
        check("R5 enter ignored in bank", grant, 0);
        press(4'd2);
        check("R5 bank 2", bank, 2);
        type_code(16'h1234);
        check("R6 no grant before enter", grant, 0);
        press(4'hE);
        check("R7 grant", grant, 1);
        check("R7 confirm", confirm, 1);
        tick();
        check("R7 grant one cycle", grant, 0);

        // R10/R5: fingerprint pass, bank sweep
        for (int b = 0; b <= 3; b++) begin
            prev_bank = bank;
            do_card();
            do_bio(1'b1);
            check("R3 no otp on match", otp, 0);
            press(4'(b));
            if (b < 3) begin
                check("R10 grant on bank", grant, 1);
                check("R10 confirm on bank", confirm, 1);
                check("R5 bank set", bank, b);
            end else begin
                check("R5 out of range no grant", grant, 0);
                check("R5 out of range bank kept", bank, prev_bank);
                press(4'd0);
                check("R10 grant after valid bank", grant, 1);
                check("R5 bank 0", bank, 0);
            end
        end

        // R6: last four digits kept, letter keys ignored
        timeout = 16'd50;
        open_code_session(16'h9071, 4'd1);
        check("R5 bank 1", bank, 1);
        press(4'd8); press(4'd8); press(4'd9); press(4'd0);
        press(4'hA); press(4'hF);
        press(4'd7); press(4'd1);
        press(4'hE);
        check("R6 last four digits match", grant, 1);

        // R8: three wrong entries cancel
        open_code_session(16'h4321, 4'd0);
        for (int a = 1; a <= 3; a++) begin
            type_code(16'h4320 + 16'(a + 3));
            press(4'hE);
            check($sformatf("R8 grant attempt %0d", a), grant, 0);
            check($sformatf("R8 cancel attempt %0d", a), cancel, (a == 3) ? 1 : 0);
        end
        check("R8 buzzer with cancel", buzzer, 1);
        check("R11 no block with cancel", blocked, 0);
        n = 1;
        for (int g = 0; g < 40 && buzzer; g++) begin
            tick();
            if (buzzer) n++;
        end
        check("R8 buzzer length", n, 8);
        do_bio(1'b0);
        check("R8 idle after cancel", otp, 0);

        // R9: counter clears on match
        open_code_session(16'h5555, 4'd1);
        type_code(16'h5554); press(4'hE);
        type_code(16'h5556); press(4'hE);
        check("R9 two wrong no cancel", cancel, 0);
        type_code(16'h5555); press(4'hE);
        check("R9 match after two wrong", grant, 1);
        // R9 new card starts fresh; R8 digits cleared after mismatch
        open_code_session(16'h0012, 4'd2);
        type_code(16'h9999); press(4'hE);
        check("R9 first wrong new card", cancel, 0);
        type_code(16'h9998); press(4'hE);
        check("R9 second wrong new card", cancel, 0);
        press(4'd1); press(4'd2); press(4'hE);
        check("R8 entry cleared after mismatch", grant, 1);
        check("R11 no cancel with grant", cancel, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule